// File: doc/BRIEF.md
# Interrupt Source PQ State Machine

This block keeps a two-bit trigger state, written {P,Q}, for each source in a small array of interrupt sources. P means an interrupt has been forwarded and not yet completed. Q means a further trigger arrived while P was set. Software and devices reach the state through a memory-mapped window. Each source has two pages there. The trigger page fires the source when it is stored to. The management page lets software read the state, load it with a chosen value through read-side-effect offsets, and complete an interrupt with a store-EOI.

Whenever a trigger or an EOI means that routing must act, the block raises a notification that carries the source number. The notification uses a valid/ready handshake toward the routing logic. Each source has a one-bit flag that records a notification which has not been sent yet. When several flags are set, the lowest source number is sent first.

The request address is laid out as {source index, page bit, offset}. Page bit 0 selects the trigger page and 1 selects the management page. The offset is OFFW bits wide, and OFFW must be at least 3.

Top module: `irq_pq_engine`

## Requirements
- R1: After reset every source holds PQ=01 (off), `notifyValid` is 0 and `rdValid` is 0.
- R2: A load (reqWrite=0) raises `rdValid` one cycle later and returns the source's PQ on `rdData` ({P,Q}, bit 1 = P). A load on the trigger page, or on a management-page offset whose top bit is 0, leaves PQ unchanged.
- R3: A management-page load at an offset whose top bit is 1 returns the PQ held before the access and sets PQ to offset bits [1:0].
- R4: A trigger-page store to a source in 00 moves it to 10 and causes a notification for that source.
- R5: A trigger-page store to a source in 10 moves it to 11 and sends no notification.
- R6: A trigger-page store to a source in 11 or 01 changes nothing and sends no notification.
- R7: A store-EOI (management-page store at offset 0) moves 10 to 00 with no notification, and moves 11 to 10 with a new notification.
- R8: A store-EOI to a source in 00 or 01 changes nothing. A management-page store at any nonzero offset is ignored.
- R9: A notification appears on `notifyValid`/`notifyIdx` two clock edges after the edge that accepts the request. It stays stable until the edge at which `notifyReady` is 1.
- R10: When several notifications are waiting, each one is sent exactly once, with the lowest source index sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request valid this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | IDXW+1+OFFW | {source index, page bit, offset} |
| rdValid | output | 1 | Load data valid |
| rdData | output | 2 | PQ value returned by the load, {P,Q} |
| notifyValid | output | 1 | Notification pending to routing |
| notifyIdx | output | IDXW | Source number of the notification |
| notifyReady | input | 1 | Routing accepts the notification |

## Verification
A wrong PQ entry stays hidden until the same source is accessed again. A get load then shows it one cycle later. A trigger or EOI then shows it two edges later, as a notification that is missing or extra. The bench therefore follows every operation with a get load, so a corrupted state shows up within the same sweep step. It sweeps every source, every starting state and every access kind. A fault in the notification flags shows up only under backpressure, as a wrong order or a repeated source number while `notifyReady` is held low.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_e;

  // Strobes from decode to the state datapath
  typedef struct packed {
    logic       hit;     // source index inside the array
    logic       doLoad;
    logic       doSet;
    logic [1:0] setVal;
    logic       doTrig;
    logic       doEoi;
  } pq_strobe_t;

  function automatic pq_e trigNext(pq_e cur);
    case (cur)
      PQ_RESET: return PQ_PEND;
      PQ_PEND:  return PQ_QUEUED;
      default:  return cur;
    endcase
  endfunction

  function automatic pq_e eoiNext(pq_e cur);
    case (cur)
      PQ_PEND:   return PQ_RESET;
      PQ_QUEUED: return PQ_PEND;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/irq_pq_ctrl.sv
module irq_pq_ctrl
  import irq_pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int OFFW    = 3
) (
  input  logic                                              reqValid,
  input  logic                                              reqWrite,
  input  logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)+OFFW:0] reqAddr,
  output pq_strobe_t                                        strobe,
  output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0]   srcIdx
);
  localparam int IDXW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int ADDRW = IDXW + 1 + OFFW;

  logic [OFFW-1:0] offset;
  logic            mgmtPage;
  logic            inRange;

  assign offset   = reqAddr[OFFW-1:0];
  assign mgmtPage = reqAddr[OFFW];
  assign srcIdx   = reqAddr[ADDRW-1:OFFW+1];
  assign inRange  = ({1'b0, srcIdx} < (IDXW+1)'(NUM_SRC));

  always_comb begin
    strobe = '0;
    strobe.hit = inRange;
    if (reqValid) begin
      if (!reqWrite) begin
        strobe.doLoad = 1'b1;
        if (mgmtPage && offset[OFFW-1] && inRange) begin
          strobe.doSet  = 1'b1;
          strobe.setVal = offset[1:0];
        end
      end else if (inRange) begin
        if (!mgmtPage) strobe.doTrig = 1'b1;
        else if (offset == '0) strobe.doEoi = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_pq_datapath.sv
module irq_pq_datapath
  import irq_pq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  pq_strobe_t                                      strobe,
  input  logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0] srcIdx,
  output logic                                            rdValid,
  output logic [1:0]                                      rdData,
  output logic                                            notifyValid,
  output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0] notifyIdx,
  input  logic                                            notifyReady
);
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  pq_e              pqArr [NUM_SRC];
  pq_e              curPq;
  pq_e              nextPq;
  logic             notifyNow;
  logic             writeEn;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] setMask;
  logic [NUM_SRC-1:0] clearMask;
  logic [IDXW-1:0]  pickIdx;
  logic             launch;

  assign curPq   = strobe.hit ? pqArr[srcIdx] : PQ_RESET;
  assign writeEn = strobe.hit & (strobe.doSet | strobe.doTrig | strobe.doEoi);

  always_comb begin
    nextPq    = curPq;
    notifyNow = 1'b0;
    if (strobe.doSet) begin
      nextPq = pq_e'(strobe.setVal);
    end else if (strobe.doTrig) begin
      nextPq    = trigNext(curPq);
      notifyNow = (curPq == PQ_RESET);
    end else if (strobe.doEoi) begin
      nextPq    = eoiNext(curPq);
      notifyNow = (curPq == PQ_QUEUED);
    end
  end

  // One state register per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN) pqArr[g] <= PQ_OFF;
      else if (writeEn && (srcIdx == IDXW'(g))) pqArr[g] <= nextPq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 2'b00;
    end else begin
      rdValid <= strobe.doLoad;
      if (strobe.doLoad) rdData <= curPq;
    end
  end

  // Lowest flagged source wins
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (flagQ[i]) pickIdx = IDXW'(i);
    end
  end

  assign launch    = (!notifyValid || notifyReady) && (|flagQ);
  assign setMask   = (notifyNow && strobe.hit) ? (NUM_SRC'(1) << srcIdx) : '0;
  assign clearMask = launch ? (NUM_SRC'(1) << pickIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ       <= '0;
      notifyValid <= 1'b0;
      notifyIdx   <= '0;
    end else begin
      flagQ <= (flagQ & ~clearMask) | setMask;
      if (launch) begin
        notifyValid <= 1'b1;
        notifyIdx   <= pickIdx;
      end else if (notifyReady) begin
        notifyValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_pq_engine.sv
module irq_pq_engine
  import irq_pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int OFFW    = 3
) (
  input  logic                                              clk,
  input  logic                                              rstN,
  input  logic                                              reqValid,
  input  logic                                              reqWrite,
  input  logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)+OFFW:0] reqAddr,
  output logic                                              rdValid,
  output logic [1:0]                                        rdData,
  output logic                                              notifyValid,
  output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0]   notifyIdx,
  input  logic                                              notifyReady
);
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  pq_strobe_t      strobe;
  logic [IDXW-1:0] srcIdx;

  irq_pq_ctrl #(.NUM_SRC(NUM_SRC), .OFFW(OFFW)) uCtrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strobe   (strobe),
    .srcIdx   (srcIdx)
  );

  irq_pq_datapath #(.NUM_SRC(NUM_SRC)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .srcIdx      (srcIdx),
    .rdValid     (rdValid),
    .rdData      (rdData),
    .notifyValid (notifyValid),
    .notifyIdx   (notifyIdx),
    .notifyReady (notifyReady)
  );

endmodule

// File: rtl/irq_pq_checker.sv
module irq_pq_checker #(
  parameter int NUM_SRC = 8,
  parameter int OFFW    = 3
) (
  input logic                                              clk,
  input logic                                              rstN,
  input logic                                              reqValid,
  input logic                                              reqWrite,
  input logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)+OFFW:0] reqAddr,
  input logic                                              rdValid,
  input logic [1:0]                                        rdData,
  input logic                                              notifyValid,
  input logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0]   notifyIdx,
  input logic                                              notifyReady
);
  localparam int IDXW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int ADDRW = IDXW + 1 + OFFW;

  logic isLoad, isMgmtGet, isMgmtSet;
  assign isLoad    = reqValid && !reqWrite;
  assign isMgmtGet = isLoad && reqAddr[OFFW] && !reqAddr[OFFW-1];
  assign isMgmtSet = isLoad && reqAddr[OFFW] && reqAddr[OFFW-1];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!notifyValid && !rdValid));

  assert_load_answers_R2: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> rdValid);

  assert_no_stray_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !isLoad |=> !rdValid);

  assert_set_then_get_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isMgmtGet && $past(isMgmtSet) &&
     (reqAddr[ADDRW-1:OFFW+1] == $past(reqAddr[ADDRW-1:OFFW+1])))
    |=> (rdData == $past(reqAddr[1:0], 2)));

  assert_notify_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (notifyValid && !notifyReady) |=> (notifyValid && $stable(notifyIdx)));

endmodule

bind irq_pq_engine irq_pq_checker #(.NUM_SRC(NUM_SRC), .OFFW(OFFW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqAddr     (reqAddr),
  .rdValid     (rdValid),
  .rdData      (rdData),
  .notifyValid (notifyValid),
  .notifyIdx   (notifyIdx),
  .notifyReady (notifyReady)
);

// File: tb/irq_pq_engine_test.sv
`timescale 1ns/1ps
module irq_pq_engine_test;
  localparam int NUM_SRC = 8;
  localparam int OFFW    = 3;
  localparam int IDXW    = 3;
  localparam int ADDRW   = IDXW + 1 + OFFW;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqWrite = 1'b0;
  logic [ADDRW-1:0] reqAddr = '0;
  logic             rdValid;
  logic [1:0]       rdData;
  logic             notifyValid;
  logic [IDXW-1:0]  notifyIdx;
  logic             notifyReady = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_pq_engine #(.NUM_SRC(NUM_SRC), .OFFW(OFFW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .rdValid(rdValid), .rdData(rdData),
    .notifyValid(notifyValid), .notifyIdx(notifyIdx), .notifyReady(notifyReady)
  );

  function automatic logic [ADDRW-1:0] mkAddr(int idx, bit mgmt, int off);
    return {IDXW'(idx), mgmt, OFFW'(off)};
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Called at a negedge; returns at a negedge two edges later
  task automatic access(input bit wr, input logic [ADDRW-1:0] a,
                        output bit rv, output logic [1:0] rd,
                        output bit nv, output logic [IDXW-1:0] ni);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a;
    @(posedge clk); @(negedge clk);
    rv = rdValid; rd = rdData;
    reqValid = 1'b0; reqWrite = 1'b0;
    @(posedge clk); @(negedge clk);
    nv = notifyValid; ni = notifyIdx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    bit rv, nv;
    logic [1:0] rd;
    logic [IDXW-1:0] ni;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 notifyValid", int'(notifyValid), 0);
    check("R1 rdValid", int'(rdValid), 0);
    for (int i = 0; i < NUM_SRC; i++) begin
      access(1'b0, mkAddr(i, 1'b1, 0), rv, rd, nv, ni);
      check("R1 reset state", int'(rd), 1);
    end

    // Sweep: every source x starting state x access kind
    for (int idx = 0; idx < NUM_SRC; idx++) begin
      for (int s = 0; s < 4; s++) begin
        for (int op = 0; op < 9; op++) begin
          bit wr;
          logic [ADDRW-1:0] a;
          int expState, expNotify;
          string tag;
          access(1'b0, mkAddr(idx, 1'b1, 4 + s), rv, rd, nv, ni);
          expState = s; expNotify = 0; wr = 0;
          case (op)
            0: begin a = mkAddr(idx, 1'b1, 0); tag = "R2 mgmt get"; end
            1: begin a = mkAddr(idx, 1'b0, 3); tag = "R2 trigger-page load"; end
            2, 3, 4, 5: begin
              a = mkAddr(idx, 1'b1, 4 + op - 2); expState = op - 2; tag = "R3 set load";
            end
            6: begin
              wr = 1; a = mkAddr(idx, 1'b0, 0);
              if (s == 0) begin expState = 2; expNotify = 1; tag = "R4 trigger"; end
              else if (s == 2) begin expState = 3; tag = "R5 trigger"; end
              else tag = "R6 trigger";
            end
            7: begin
              wr = 1; a = mkAddr(idx, 1'b1, 0);
              if (s == 2) begin expState = 0; tag = "R7 eoi"; end
              else if (s == 3) begin expState = 2; expNotify = 1; tag = "R7 eoi"; end
              else tag = "R8 eoi";
            end
            default: begin wr = 1; a = mkAddr(idx, 1'b1, 5); tag = "R8 stray store"; end
          endcase
          access(wr, a, rv, rd, nv, ni);
          check({tag, " rdValid"}, int'(rv), wr ? 0 : 1);
          if (!wr) check({tag, " old value"}, int'(rd), s);
          check({tag, " notify"}, int'(nv), expNotify);
          if (expNotify != 0) check({tag, " R9 notifyIdx"}, int'(ni), idx);
          access(1'b0, mkAddr(idx, 1'b1, 1), rv, rd, nv, ni);
          check({tag, " new state"}, int'(rd), expState);
          check({tag, " no stray notify"}, int'(nv), 0);
        end
      end
    end

    // Backpressure and ordering
    notifyReady = 1'b0;
    access(1'b0, mkAddr(5, 1'b1, 4), rv, rd, nv, ni);
    access(1'b0, mkAddr(2, 1'b1, 4), rv, rd, nv, ni);
    access(1'b0, mkAddr(6, 1'b1, 4), rv, rd, nv, ni);
    access(1'b1, mkAddr(5, 1'b0, 0), rv, rd, nv, ni);
    check("R9 first notify valid", int'(nv), 1);
    check("R9 first notify idx", int'(ni), 5);
    access(1'b1, mkAddr(2, 1'b0, 0), rv, rd, nv, ni);
    access(1'b1, mkAddr(6, 1'b0, 0), rv, rd, nv, ni);
    repeat (5) @(negedge clk);
    check("R9 held valid", int'(notifyValid), 1);
    check("R9 held idx", int'(notifyIdx), 5);
    notifyReady = 1'b1;
    @(negedge clk);
    notifyReady = 1'b0;
    check("R10 second valid", int'(notifyValid), 1);
    check("R10 lowest next", int'(notifyIdx), 2);
    repeat (3) @(negedge clk);
    check("R9 held second", int'(notifyIdx), 2);
    notifyReady = 1'b1;
    @(negedge clk);
    check("R10 third idx", int'(notifyIdx), 6);
    check("R10 third valid", int'(notifyValid), 1);
    @(negedge clk);
    check("R10 each once", int'(notifyValid), 0);
    repeat (3) @(negedge clk);
    check("R10 drained", int'(notifyValid), 0);

    finish();
  end

endmodule